// File: doc/BRIEF.md
# Fast Ethernet PHY Control and Status Registers

This block holds the two basic management registers of a Fast Ethernet PHY: a read/write control word at address 0 and a read-only capability word at address 1. Software reaches them through a simple synchronous port with an address, a write enable, 16-bit write data and a combinational 16-bit read path. Every other address reads as zero, and writes to it are dropped.

Two power-up strap inputs give the reset values of the auto-negotiation enable and of the forced speed. This lets a board bring the PHY up with negotiation held off, so that software can program the advertised abilities before the first negotiation. The block drives the PHY core with the effective speed and duplex, the negotiation enable, a one-cycle negotiation restart pulse, an isolate level, a loopback level and a transmit-inhibit level.

The MDIO serial framing, the negotiation engine, the analog front end and all other registers sit outside this block.

Top module: `phy_mgmt_regs`

## Requirements
- R1: On reset, negotiation enable takes `strap_an_en`. The speed bit takes `strap_speed` when `strap_an_en` is 0 and 1 otherwise. The duplex bit resets to 1. Loopback, power-down, isolate and restart reset to 0.
- R2: Control word fields: bit 14 loopback, bit 13 speed select (1 = 100 Mb/s), bit 12 negotiation enable, bit 11 power-down, bit 10 isolate, bit 9 restart, bit 8 duplex (1 = full). Bit 15, bit 7 (collision test) and bits 6..0 always read 0.
- R3: While negotiation is disabled, `speed_100` follows bit 13 and `full_duplex` follows bit 8. While it is enabled, both outputs are 1 whatever those bits hold.
- R4: A write to address 0 that sets bit 12 while it is 0 raises `an_restart` for exactly the clock cycle after the write edge. A write that keeps bit 12 at 1 without bit 9 gives no pulse.
- R5: A write to address 0 with bit 9 set and bit 12 set pulses `an_restart` in the same way. Any write with bit 12 cleared gives no pulse, even with bit 9 set.
- R6: The restart bit reads 1 only during the pulse cycle and reads 0 from the next cycle on.
- R7: `loopback` and `tx_inhibit` both equal bit 14.
- R8: `isolate` equals bit 10.
- R9: The power-down bit is stored and read back but changes no output.
- R10: Address 1 reads 0x7800 (bits 14..11 set, all other bits 0). Writes to it change no state.
- R11: Any address other than 0 and 1 reads 0x0000. Writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_an_en | input | 1 | Power-up value of negotiation enable |
| strap_speed | input | 1 | Power-up forced speed when negotiation is strapped off |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| speed_100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Effective duplex, 1 = full |
| an_enable | output | 1 | Negotiation enabled |
| an_restart | output | 1 | One-cycle negotiation restart pulse |
| isolate | output | 1 | Isolate the reduced-MII receive side and ignore transmit |
| loopback | output | 1 | Loopback mode |
| tx_inhibit | output | 1 | Block transmission onto the line |

## Verification
Two causes of a restart can fall in the same write: a 0-to-1 step of the negotiation enable and a set restart bit. The bench provokes this by writing both bits at once while negotiation is off. It also writes a restart bit together with a cleared enable bit. Its reference model expects one pulse in the first case and none in the second, and it compares the pulse and the read-back restart bit with the model on every clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int REG_W = 16;

    localparam int BIT_LOOP    = 14;
    localparam int BIT_SPEED   = 13;
    localparam int BIT_AN      = 12;
    localparam int BIT_PDOWN   = 11;
    localparam int BIT_ISO     = 10;
    localparam int BIT_RESTART = 9;
    localparam int BIT_DUPLEX  = 8;

    localparam logic [REG_W-1:0] STATUS_CAPS = 16'h7800;

    typedef struct packed {
        logic loopback;
        logic speed_sel;
        logic an_en;
        logic pdown;
        logic isolate;
        logic duplex;
    } ctrl_t;

    typedef struct packed {
        logic speed_100;
        logic full_duplex;
    } link_mode_t;

    function automatic ctrl_t ctrl_defaults(input logic strap_an, input logic strap_spd);
        ctrl_t c;
        c.loopback  = 1'b0;
        c.speed_sel = strap_an ? 1'b1 : strap_spd;
        c.an_en     = strap_an;
        c.pdown     = 1'b0;
        c.isolate   = 1'b0;
        c.duplex    = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.loopback  = w[BIT_LOOP];
        c.speed_sel = w[BIT_SPEED];
        c.an_en     = w[BIT_AN];
        c.pdown     = w[BIT_PDOWN];
        c.isolate   = w[BIT_ISO];
        c.duplex    = w[BIT_DUPLEX];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c, input logic restart);
        logic [REG_W-1:0] w;
        w              = '0;
        w[BIT_LOOP]    = c.loopback;
        w[BIT_SPEED]   = c.speed_sel;
        w[BIT_AN]      = c.an_en;
        w[BIT_PDOWN]   = c.pdown;
        w[BIT_ISO]     = c.isolate;
        w[BIT_RESTART] = restart;
        w[BIT_DUPLEX]  = c.duplex;
        return w;
    endfunction

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_an,
    input  logic             strap_spd,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic             restart
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_nxt;
    logic  restart_q;
    logic  want_restart;

    always_comb begin
        ctrl_nxt     = ctrl_unpack(wr_data);
        want_restart = ctrl_nxt.an_en && (!ctrl_q.an_en || wr_data[BIT_RESTART]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= ctrl_defaults(strap_an, strap_spd);
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (wr_sel) begin
                ctrl_q    <= ctrl_nxt;
                restart_q <= want_restart;
            end
        end
    end

    assign ctrl    = ctrl_q;
    assign restart = restart_q;
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
    import phy_mgmt_pkg::*;
(
    input  logic       an_en,
    input  logic       speed_sel,
    input  logic       duplex,
    output link_mode_t mode
);
    always_comb begin
        if (an_en) begin
            mode.speed_100   = 1'b1;
            mode.full_duplex = 1'b1;
        end else begin
            mode.speed_100   = speed_sel;
            mode.full_duplex = duplex;
        end
    end
endmodule

// File: rtl/phy_status_reg.sv
module phy_status_reg
    import phy_mgmt_pkg::*;
#(
    parameter logic [REG_W-1:0] CAPS = STATUS_CAPS
) (
    output logic [REG_W-1:0] value
);
    for (genvar i = 0; i < REG_W; i++) begin : g_cap
        if (CAPS[i]) begin : g_one
            assign value[i] = 1'b1;
        end else begin : g_zero
            assign value[i] = 1'b0;
        end
    end
endmodule

// File: rtl/phy_rd_mux.sv
module phy_rd_mux
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  ctrl_word,
    input  logic [REG_W-1:0]  stat_word,
    output logic [REG_W-1:0]  rd_data
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_ADDR);

    always_comb begin
        if (addr == CA)      rd_data = ctrl_word;
        else if (addr == SA) rd_data = stat_word;
        else                 rd_data = '0;
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_an_en,
    input  logic              strap_speed,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              speed_100,
    output logic              full_duplex,
    output logic              an_enable,
    output logic              an_restart,
    output logic              isolate,
    output logic              loopback,
    output logic              tx_inhibit
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);

    ctrl_t            ctrl;
    logic             restart;
    link_mode_t       mode;
    logic [REG_W-1:0] ctrl_word;
    logic [REG_W-1:0] stat_word;
    logic             ctrl_wr;

    assign ctrl_wr = wr_en && (addr == CA);

    phy_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .strap_an  (strap_an_en),
        .strap_spd (strap_speed),
        .wr_sel    (ctrl_wr),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .restart   (restart)
    );

    phy_mode_resolve u_mode (
        .an_en     (ctrl.an_en),
        .speed_sel (ctrl.speed_sel),
        .duplex    (ctrl.duplex),
        .mode      (mode)
    );

    phy_status_reg #(.CAPS(STATUS_CAPS)) u_stat (
        .value (stat_word)
    );

    assign ctrl_word = ctrl_pack(ctrl, restart);

    phy_rd_mux #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_rd (
        .addr      (addr),
        .ctrl_word (ctrl_word),
        .stat_word (stat_word),
        .rd_data   (rd_data)
    );

    assign speed_100   = mode.speed_100;
    assign full_duplex = mode.full_duplex;
    assign an_enable   = ctrl.an_en;
    assign an_restart  = restart;
    assign isolate     = ctrl.isolate;
    assign loopback    = ctrl.loopback;
    assign tx_inhibit  = ctrl.loopback;
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [15:0]       wr_data,
    input logic [15:0]       rd_data,
    input logic              speed_100,
    input logic              full_duplex,
    input logic              an_enable,
    input logic              an_restart,
    input logic              tx_inhibit
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_ADDR);

    // R2
    coltest_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == CA) |-> (rd_data[7] == 1'b0 && rd_data[15] == 1'b0));

    // R3
    forced_speed_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == CA && !an_enable) |-> (speed_100 == rd_data[13] && full_duplex == rd_data[8]));

    // R3
    an_mode_chk: assert property (@(posedge clk) disable iff (rst)
        an_enable |-> (speed_100 && full_duplex));

    // R4
    restart_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        an_restart |-> an_enable);

    // R4
    restart_cause_chk: assert property (@(posedge clk) disable iff (rst)
        an_restart |-> $past(wr_en && addr == CA));

    // R5
    no_restart_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CA && !wr_data[12]) |=> !an_restart);

    // R6
    restart_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == CA) |-> (rd_data[9] == an_restart));

    // R7
    tx_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == CA) |-> (tx_inhibit == rd_data[14]));

    // R10
    status_const_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == SA) |-> (rd_data == 16'h7800));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr != CA && addr != SA) |-> (rd_data == 16'h0000));
endmodule

bind phy_mgmt_regs phy_mgmt_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .speed_100   (speed_100),
    .full_duplex (full_duplex),
    .an_enable   (an_enable),
    .an_restart  (an_restart),
    .tx_inhibit  (tx_inhibit)
);

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_an_en = 1'b0;
    logic        strap_speed = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        speed_100, full_duplex, an_enable, an_restart;
    logic        isolate, loopback, tx_inhibit;

    always #5 clk = ~clk;

    phy_mgmt_regs u_phy_mgmt_regs (
        .clk(clk), .rst(rst), .strap_an_en(strap_an_en), .strap_speed(strap_speed),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .speed_100(speed_100), .full_duplex(full_duplex), .an_enable(an_enable),
        .an_restart(an_restart), .isolate(isolate), .loopback(loopback),
        .tx_inhibit(tx_inhibit)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_loop, m_spd, m_an, m_pd, m_iso, m_dup, m_pulse;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [4:0] a);
        int v;
        if (a == 5'd0)
            v = m_loop*16384 + m_spd*8192 + m_an*4096 + m_pd*2048
              + m_iso*1024 + m_pulse*512 + m_dup*256;
        else if (a == 5'd1)
            v = 30720;
        else
            v = 0;
        return 16'(v);
    endfunction

    task automatic step(input logic r, input logic [4:0] a, input logic we,
                        input logic [15:0] d, input string tag);
        rst = r; addr = a; wr_en = we; wr_data = d;
        @(posedge clk);
        if (r) begin
            m_an = strap_an_en; m_spd = strap_an_en ? 1 : int'(strap_speed);
            m_dup = 1; m_loop = 0; m_pd = 0; m_iso = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (we && a == 5'd0) begin
                m_pulse = (d[12] && (m_an == 0 || d[9])) ? 1 : 0;
                m_loop = d[14]; m_spd = d[13]; m_an = d[12];
                m_pd = d[11]; m_iso = d[10]; m_dup = d[8];
            end
        end
        @(negedge clk);
        chk({tag, " rd_data"}, rd_data, exp_rd(a));
        chk("R3 speed_100", 16'(speed_100), 16'(m_an != 0 ? 1 : m_spd));
        chk("R3 full_duplex", 16'(full_duplex), 16'(m_an != 0 ? 1 : m_dup));
        chk("R2 an_enable", 16'(an_enable), 16'(m_an));
        chk("R4 an_restart", 16'(an_restart), 16'(m_pulse));
        chk("R7 loopback", 16'(loopback), 16'(m_loop));
        chk("R7 tx_inhibit", 16'(tx_inhibit), 16'(m_loop));
        chk("R8 isolate", 16'(isolate), 16'(m_iso));
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 straps: negotiation off, 10 Mb/s
        step(1'b1, 5'd0, 1'b0, 16'h0000, "R1 reset");
        step(1'b1, 5'd0, 1'b0, 16'h0000, "R1 reset");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R1 defaults");
        step(1'b0, 5'd1, 1'b0, 16'h0000, "R10 status read");
        // R3 forced modes
        step(1'b0, 5'd0, 1'b1, 16'h2000, "R3 forced 100 half");
        step(1'b0, 5'd0, 1'b1, 16'h0100, "R3 forced 10 full");
        // R5 restart ignored while disabled
        step(1'b0, 5'd0, 1'b1, 16'h0200, "R5 restart while off");
        // R4 re-enable, R6 self-clear
        step(1'b0, 5'd0, 1'b1, 16'h1000, "R4 re-enable");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R6 self-clear");
        step(1'b0, 5'd0, 1'b1, 16'h1200, "R5 restart while on");
        step(1'b0, 5'd0, 1'b1, 16'h1200, "R5 back-to-back restart");
        step(1'b0, 5'd0, 1'b1, 16'h1000, "R4 enable kept");
        // Coincident causes
        step(1'b0, 5'd0, 1'b1, 16'h0200, "R5 clear with restart");
        step(1'b0, 5'd0, 1'b1, 16'h1200, "R4 enable with restart");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R6 self-clear");
        // R9 power-down stored only
        step(1'b0, 5'd0, 1'b1, 16'h2900, "R9 power-down");
        step(1'b0, 5'd0, 1'b1, 16'h4400, "R7 R8 loopback isolate");
        // R2 reserved and collision bits read 0
        step(1'b0, 5'd0, 1'b1, 16'hFFFF, "R2 all ones");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R2 all ones after");
        // R10 and R11 writes dropped
        step(1'b0, 5'd1, 1'b1, 16'h0000, "R10 write status");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R10 ctrl untouched");
        step(1'b0, 5'd7, 1'b1, 16'h0000, "R11 write unmapped");
        step(1'b0, 5'd31, 1'b0, 16'h0000, "R11 read unmapped");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R11 ctrl untouched");
        // R1 straps: negotiation on
        strap_an_en = 1'b1; strap_speed = 1'b0;
        step(1'b1, 5'd0, 1'b0, 16'h0000, "R1 strap an reset");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R1 strap an defaults");
        step(1'b0, 5'd0, 1'b1, 16'h0000, "R3 forced 10 half");
        // R1 straps: negotiation off, 100 Mb/s
        strap_an_en = 1'b0; strap_speed = 1'b1;
        step(1'b1, 5'd0, 1'b0, 16'h0000, "R1 strap speed reset");
        step(1'b0, 5'd0, 1'b0, 16'h0000, "R1 strap speed defaults");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule